// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits in the receive path of an HDLC controller, after flag detection and zero-bit removal. It gets the destuffed byte stream together with strobes that mark the opening flag, the closing flag and an abort. For each frame it decides whether to keep the frame, by comparing the first byte after the opening flag with a programmed station address. Downstream logic sees only the bytes, end strobes and abort strobes of frames that were kept. A level output qualifies the frame currently being passed.

Two registers are reached through a small synchronous write port: a control register and an address register. The controls are receive enable, address-detect enable, a select that narrows the compare from seven to six upper bits, and transparent mode. Filtering works packet by packet. Clearing receive enable in the middle of a frame takes effect only after that frame has closed or aborted. In transparent mode there is no framing: every byte is passed on, and clearing receive enable stops the stream at once.

Top module: `hdlc_rx_addr_filter`

## Requirements
- R1: With address detection off (control bit 1 = 0), every frame that receives an address byte is accepted, whatever that byte holds.
- R2: With detection on and the six-bit select low (control bit 2 = 0), a frame is accepted when bits [7:1] of its first byte equal bits [7:1] of the address register. Bit 0 is ignored.
- R3: In seven-bit mode, a first byte with bits [7:1] all ones is accepted as an all-call, whatever the address register holds.
- R4: With the six-bit select high, only bits [7:2] are compared. A first byte with bits [7:2] all ones is an all-call.
- R5: The six-bit select has no effect while address detection is off.
- R6: A rejected frame produces no byte, end or abort strobe at the outputs, and `frm_accept` stays low for that frame.
- R7: Clearing receive enable (control bit 0) during a frame lets that frame complete, including its end or abort strobe. Later opening flags are ignored until enable is set again.
- R8: In transparent mode (control bit 3 = 1) with receive enable set, every input byte strobe is passed on one cycle later, and start, end and abort strobes are ignored. A byte arriving in the cycle after a write that clears receive enable is not passed.
- R9: A frame that ends or aborts before its address byte produces no strobes and no accept.
- R10: A write with `cfg_sel` = 0 loads the control register and with `cfg_sel` = 1 loads the address register. The address, detect and six-bit settings are captured at each opening flag, so a change made during a frame applies from the next frame.
- R11: For an accepted frame, each input byte appears on `out_byte` with `out_byte_vld` one cycle after its input strobe, starting with the address byte. `frm_accept` is high from the cycle after the address byte until the cycle of the one-cycle `out_eof` or `out_abort` pulse. If strobes coincide, the priority is abort, then end, then start, then byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = control register, 1 = address register |
| cfg_wdata | input | 8 | Write data |
| in_byte | input | 8 | Destuffed receive byte |
| in_byte_vld | input | 1 | Byte strobe |
| in_sof | input | 1 | Opening flag seen |
| in_eof | input | 1 | Closing flag seen |
| in_abort | input | 1 | Abort seen |
| out_byte | output | 8 | Forwarded byte |
| out_byte_vld | output | 1 | Forwarded byte strobe |
| out_eof | output | 1 | End of an accepted frame |
| out_abort | output | 1 | Abort of an accepted frame |
| frm_accept | output | 1 | Current frame is accepted |

## Verification
The bench targets several corner cases, each with a distinct failure signature:
- Address bytes that differ from the station only in bit 0, or only in bits 1..0 in six-bit mode. A design that compares too many bits rejects them.
- All-call bytes such as 0xFE and 0xFC. A design with the wrong wildcard width either rejects them or lets 0xFC through in seven-bit mode.
- Clearing enable mid-frame. An eager design cuts off the tail bytes and the end strobe.
- Rewriting the address between the opening flag and the address byte. A design without the per-frame capture matches against the new value.
- Frames that end before their address byte. A design that leaks these emits stray strobes.
- Transparent-mode shutdown. A design that lags lets one more byte out after the write.

// File: rtl/hrf_pkg.sv
package hrf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_PASS = 2'd2,
        ST_DROP = 2'd3
    } frm_st_t;

    typedef struct packed {
        logic trn;
        logic six_sel;
        logic det_en;
        logic rx_en;
    } ctl_t;

    localparam int CTL_BIT_EN  = 0;
    localparam int CTL_BIT_DET = 1;
    localparam int CTL_BIT_SIX = 2;
    localparam int CTL_BIT_TRN = 3;

endpackage

// File: rtl/hrf_cfg_regs.sv
module hrf_cfg_regs
    import hrf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output ctl_t              ctl,
    output logic [DATA_W-1:0] own_addr
);

    typedef struct packed {
        ctl_t              ctl;
        logic [DATA_W-1:0] addr;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_sel) begin
                regs_d.addr = wr_data;
            end else begin
                regs_d.ctl.rx_en   = wr_data[CTL_BIT_EN];
                regs_d.ctl.det_en  = wr_data[CTL_BIT_DET];
                regs_d.ctl.six_sel = wr_data[CTL_BIT_SIX];
                regs_d.ctl.trn     = wr_data[CTL_BIT_TRN];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ctl      = regs_q.ctl;
    assign own_addr = regs_q.addr;

    // R10: an address write leaves control untouched and vice versa
    assert_addr_write_keeps_ctl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> $stable(ctl));

endmodule

// File: rtl/hrf_addr_match.sv
module hrf_addr_match #(
    parameter int DATA_W  = 8,
    parameter int LONG_W  = 7,
    parameter int SHORT_W = 6
) (
    input  logic [DATA_W-1:0] rx_addr,
    input  logic [DATA_W-1:0] own_addr,
    input  logic              det_en,
    input  logic              six_sel,
    output logic              hit
);

    localparam logic [DATA_W-1:0] LONG_MASK  = {{LONG_W{1'b1}},  {(DATA_W-LONG_W){1'b0}}};
    localparam logic [DATA_W-1:0] SHORT_MASK = {{SHORT_W{1'b1}}, {(DATA_W-SHORT_W){1'b0}}};

    logic [DATA_W-1:0] diff_long, diff_short;
    logic [DATA_W-1:0] ones_long, ones_short;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign diff_long[i]  = (rx_addr[i] ^ own_addr[i]) & LONG_MASK[i];
        assign diff_short[i] = (rx_addr[i] ^ own_addr[i]) & SHORT_MASK[i];
        assign ones_long[i]  = rx_addr[i] | ~LONG_MASK[i];
        assign ones_short[i] = rx_addr[i] | ~SHORT_MASK[i];
    end

    logic long_hit, short_hit;

    always_comb begin
        long_hit  = (diff_long == '0)  || (&ones_long);
        short_hit = (diff_short == '0) || (&ones_short);
        if (!det_en) begin
            hit = 1'b1;
        end else if (six_sel) begin
            hit = short_hit;
        end else begin
            hit = long_hit;
        end
    end

    // R1 and R5: with detection off the select and the byte do not matter
    always_comb begin
        if (det_en == 1'b0) begin
            assert_no_filter_when_off_R1: assert (hit);
        end
    end

    // R3: a seven-bit all-call is always a hit in seven-bit mode
    always_comb begin
        if (det_en && !six_sel && (&rx_addr[DATA_W-1 -: LONG_W])) begin
            assert_allcall_long_R3: assert (hit);
        end
    end

endmodule

// File: rtl/hrf_frame_fsm.sv
module hrf_frame_fsm
    import hrf_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int LONG_W  = 7,
    parameter int SHORT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] own_addr,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              in_byte_vld,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_abort,
    output logic [DATA_W-1:0] out_byte,
    output logic              out_byte_vld,
    output logic              out_eof,
    output logic              out_abort,
    output logic              frm_accept
);

    typedef struct packed {
        frm_st_t           st;
        logic [DATA_W-1:0] cap_addr;
        logic              cap_det;
        logic              cap_six;
        logic [DATA_W-1:0] obyte;
        logic              ovld;
        logic              oeof;
        logic              oabort;
    } fsm_t;

    fsm_t s_d, s_q;
    logic addr_hit;

    hrf_addr_match #(
        .DATA_W (DATA_W),
        .LONG_W (LONG_W),
        .SHORT_W(SHORT_W)
    ) match_i (
        .rx_addr (in_byte),
        .own_addr(s_q.cap_addr),
        .det_en  (s_q.cap_det),
        .six_sel (s_q.cap_six),
        .hit     (addr_hit)
    );

    always_comb begin
        s_d        = s_q;
        s_d.ovld   = 1'b0;
        s_d.oeof   = 1'b0;
        s_d.oabort = 1'b0;
        if (ctl.trn) begin
            s_d.st = ST_IDLE;
            if (ctl.rx_en && in_byte_vld) begin
                s_d.ovld  = 1'b1;
                s_d.obyte = in_byte;
            end
        end else if (in_abort) begin
            s_d.oabort = (s_q.st == ST_PASS);
            s_d.st     = ST_IDLE;
        end else if (in_eof) begin
            s_d.oeof = (s_q.st == ST_PASS);
            s_d.st   = ST_IDLE;
        end else if (in_sof) begin
            if (ctl.rx_en) begin
                s_d.st       = ST_WAIT;
                s_d.cap_addr = own_addr;
                s_d.cap_det  = ctl.det_en;
                s_d.cap_six  = ctl.six_sel;
            end else begin
                s_d.st = ST_IDLE;
            end
        end else if (in_byte_vld) begin
            unique case (s_q.st)
                ST_WAIT: begin
                    if (addr_hit) begin
                        s_d.st    = ST_PASS;
                        s_d.ovld  = 1'b1;
                        s_d.obyte = in_byte;
                    end else begin
                        s_d.st = ST_DROP;
                    end
                end
                ST_PASS: begin
                    s_d.ovld  = 1'b1;
                    s_d.obyte = in_byte;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_byte     = s_q.obyte;
    assign out_byte_vld = s_q.ovld;
    assign out_eof      = s_q.oeof;
    assign out_abort    = s_q.oabort;
    assign frm_accept   = (s_q.st == ST_PASS);

    // R9: a frame closed while waiting for its address byte leaves no trace
    assert_early_end_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_WAIT && !ctl.trn && (in_eof || in_abort))
        |=> (!frm_accept && !out_eof && !out_abort && !out_byte_vld));

    // R6: a dropped frame stays dropped until a flag or abort
    assert_drop_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DROP && !ctl.trn && !in_eof && !in_abort && !in_sof)
        |=> (!out_byte_vld && !frm_accept));

    // R7: an accepted frame keeps passing bytes whatever receive enable says
    assert_pass_continues_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_accept && !ctl.trn && in_byte_vld && !in_eof && !in_abort && !in_sof)
        |=> (out_byte_vld && out_byte == $past(in_byte)));

endmodule

// File: rtl/hdlc_rx_addr_filter.sv
module hdlc_rx_addr_filter
    import hrf_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int LONG_W  = 7,
    parameter int SHORT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              in_byte_vld,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_abort,
    output logic [DATA_W-1:0] out_byte,
    output logic              out_byte_vld,
    output logic              out_eof,
    output logic              out_abort,
    output logic              frm_accept
);

    ctl_t              ctl;
    logic [DATA_W-1:0] own_addr;

    hrf_cfg_regs #(
        .DATA_W(DATA_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .ctl     (ctl),
        .own_addr(own_addr)
    );

    hrf_frame_fsm #(
        .DATA_W (DATA_W),
        .LONG_W (LONG_W),
        .SHORT_W(SHORT_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl         (ctl),
        .own_addr    (own_addr),
        .in_byte     (in_byte),
        .in_byte_vld (in_byte_vld),
        .in_sof      (in_sof),
        .in_eof      (in_eof),
        .in_abort    (in_abort),
        .out_byte    (out_byte),
        .out_byte_vld(out_byte_vld),
        .out_eof     (out_eof),
        .out_abort   (out_abort),
        .frm_accept  (frm_accept)
    );

    // R6: bytes leave only for an accepted frame or in transparent mode
    assert_no_leak_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_byte_vld |-> (frm_accept || $past(ctl.trn && ctl.rx_en)));

    // R11: end and abort pulses close an accepted frame and last one cycle
    assert_eof_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> ($past(frm_accept) && !frm_accept));
    assert_abort_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_abort |-> ($past(frm_accept) && !frm_accept));
    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_eof, out_abort}));

    // R8: transparent mode with enable cleared passes nothing
    assert_trn_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.trn && !ctl.rx_en && in_byte_vld) |=> !out_byte_vld);

endmodule

// File: tb/hdlc_rx_addr_filter_tb_top.sv
module hdlc_rx_addr_filter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] in_byte = '0;
    logic       in_byte_vld = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_abort = 1'b0;
    logic [7:0] out_byte;
    logic       out_byte_vld, out_eof, out_abort, frm_accept;

    always #10 clk = ~clk;

    hdlc_rx_addr_filter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .in_byte(in_byte), .in_byte_vld(in_byte_vld), .in_sof(in_sof), .in_eof(in_eof),
        .in_abort(in_abort), .out_byte(out_byte), .out_byte_vld(out_byte_vld),
        .out_eof(out_eof), .out_abort(out_abort), .frm_accept(frm_accept)
    );

    int    n_tests = 0, n_fail = 0;
    string cur_req = "R11";
    bit    done = 0;

    // behavioural reference model
    bit       m_en, m_det, m_six, m_trn, s_det, s_six;
    bit [7:0] m_addr, s_addr, e_byte;
    int       m_st;  // 0 idle, 1 await address, 2 passing, 3 dropping
    bit       e_vld, e_eof, e_abt, e_acc;

    function automatic bit want(bit [7:0] rx, bit [7:0] own, bit det, bit six);
        int k = six ? 2 : 1;
        if (!det) return 1;
        return ((rx >> k) == (own >> k)) || ((rx >> k) == (8'hFF >> k));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_en, m_det, m_six, m_trn, s_det, s_six} = '0;
            m_addr = 0; s_addr = 0; e_byte = 0; m_st = 0;
            {e_vld, e_eof, e_abt, e_acc} = '0;
        end else begin
            e_vld = 0; e_eof = 0; e_abt = 0;
            if (m_trn) begin
                m_st = 0;
                if (m_en && in_byte_vld) begin e_vld = 1; e_byte = in_byte; end
            end else if (in_abort) begin
                e_abt = (m_st == 2); m_st = 0;
            end else if (in_eof) begin
                e_eof = (m_st == 2); m_st = 0;
            end else if (in_sof) begin
                if (m_en) begin m_st = 1; s_addr = m_addr; s_det = m_det; s_six = m_six; end
                else m_st = 0;
            end else if (in_byte_vld) begin
                if (m_st == 1) begin
                    if (want(in_byte, s_addr, s_det, s_six)) begin
                        m_st = 2; e_vld = 1; e_byte = in_byte;
                    end else m_st = 3;
                end else if (m_st == 2) begin
                    e_vld = 1; e_byte = in_byte;
                end
            end
            e_acc = (m_st == 2);
            if (cfg_we) begin
                if (cfg_sel) m_addr = cfg_wdata;
                else {m_trn, m_six, m_det, m_en} = cfg_wdata[3:0];
            end
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    int fwd_cnt = 0, eof_cnt = 0, abt_cnt = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(out_byte_vld == e_vld, cur_req, "out_byte_vld", out_byte_vld, e_vld);
            if (e_vld) chk(out_byte == e_byte, cur_req, "out_byte", out_byte, e_byte);
            chk(out_eof == e_eof, cur_req, "out_eof", out_eof, e_eof);
            chk(out_abort == e_abt, cur_req, "out_abort", out_abort, e_abt);
            chk(frm_accept == e_acc, cur_req, "frm_accept", frm_accept, e_acc);
            fwd_cnt += out_byte_vld; eof_cnt += out_eof; abt_cnt += out_abort;
        end
    end

    task automatic cyc(bit sof, bit eof, bit abt, bit vld, bit [7:0] b);
        @(negedge clk); #2;
        cfg_we = 0; in_sof = sof; in_eof = eof; in_abort = abt; in_byte_vld = vld; in_byte = b;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 8'h00);
    endtask

    task automatic wr(bit sel, bit [7:0] d);
        @(negedge clk); #2;
        {in_sof, in_eof, in_abort, in_byte_vld} = '0;
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    endtask

    task automatic frame(bit [7:0] a, int npay, bit abt, int x_fwd, int x_eof, int x_abt, string req);
        int f0, e0, a0;
        cur_req = req;
        idle(1);
        f0 = fwd_cnt; e0 = eof_cnt; a0 = abt_cnt;
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, a);
        for (int i = 0; i < npay; i++) cyc(0, 0, 0, 1, 8'h30 + 8'(i));
        if (abt) cyc(0, 0, 1, 0, 0); else cyc(0, 1, 0, 0, 0);
        idle(2);
        chk(fwd_cnt - f0 == x_fwd, req, "bytes forwarded", fwd_cnt - f0, x_fwd);
        chk(eof_cnt - e0 == x_eof, req, "end pulses", eof_cnt - e0, x_eof);
        chk(abt_cnt - a0 == x_abt, req, "abort pulses", abt_cnt - a0, x_abt);
    endtask

    initial begin
        #(200000 * 20);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        cur_req = "R10";
        chk(!out_byte_vld && !out_eof && !out_abort && !frm_accept, "R10", "reset outputs",
            {out_byte_vld, out_eof, out_abort, frm_accept}, 0);

        // disabled receiver: nothing passes
        frame(8'h55, 2, 0, 0, 0, 0, "R7");

        // detection off: any address accepted
        wr(0, 8'h01);
        frame(8'h55, 3, 0, 4, 1, 0, "R1");
        wr(0, 8'h05);  // six select with detection off
        frame(8'h13, 1, 0, 2, 1, 0, "R5");

        // seven-bit compare
        wr(1, 8'h40);
        wr(0, 8'h03);
        frame(8'h41, 2, 0, 3, 1, 0, "R2");
        frame(8'h40, 0, 0, 1, 1, 0, "R2");
        frame(8'h42, 2, 0, 0, 0, 0, "R6");
        frame(8'hFE, 1, 0, 2, 1, 0, "R3");
        frame(8'hFF, 1, 1, 2, 0, 1, "R3");
        frame(8'hFC, 2, 0, 0, 0, 0, "R3");

        // six-bit compare
        wr(0, 8'h07);
        frame(8'h43, 1, 0, 2, 1, 0, "R4");
        frame(8'hFC, 1, 0, 2, 1, 0, "R4");
        frame(8'h44, 1, 0, 0, 0, 0, "R4");

        // frame ending or aborting before its address byte
        cur_req = "R9";
        f0 = fwd_cnt;
        cyc(1, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0);
        cyc(1, 0, 0, 0, 0); cyc(0, 0, 1, 0, 0);
        idle(2);
        chk(fwd_cnt == f0 && !frm_accept, "R9", "early end", fwd_cnt - f0, 0);

        // address changed between the opening flag and the address byte
        wr(0, 8'h03);
        cur_req = "R10";
        f0 = fwd_cnt;
        cyc(1, 0, 0, 0, 0);
        wr(1, 8'h20);
        cyc(0, 0, 0, 1, 8'h40);
        cyc(0, 1, 0, 0, 0);
        idle(2);
        chk(fwd_cnt - f0 == 1, "R10", "old address used", fwd_cnt - f0, 1);
        frame(8'h20, 1, 0, 2, 1, 0, "R10");
        frame(8'h40, 1, 0, 0, 0, 0, "R10");

        // enable cleared mid-frame
        cur_req = "R7";
        f0 = fwd_cnt;
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 8'h21);
        wr(0, 8'h02);
        cyc(0, 0, 0, 1, 8'h77);
        cyc(0, 0, 0, 1, 8'h78);
        cyc(0, 1, 0, 0, 0);
        idle(2);
        chk(fwd_cnt - f0 == 3, "R7", "tail of frame kept", fwd_cnt - f0, 3);
        frame(8'h20, 2, 0, 0, 0, 0, "R7");

        // transparent mode
        wr(0, 8'h09);
        cur_req = "R8";
        f0 = fwd_cnt;
        cyc(0, 0, 0, 1, 8'hA1);
        cyc(1, 0, 0, 1, 8'hA2);
        cyc(0, 1, 0, 1, 8'hA3);
        wr(0, 8'h08);
        cyc(0, 0, 0, 1, 8'hA4);
        cyc(0, 0, 0, 1, 8'hA5);
        idle(2);
        chk(fwd_cnt - f0 == 3, "R8", "transparent stop", fwd_cnt - f0, 3);

        // coincident strobes: abort wins over end
        wr(0, 8'h01);
        cur_req = "R11";
        f0 = abt_cnt;
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 8'h99);
        cyc(0, 1, 1, 0, 0);
        idle(2);
        chk(abt_cnt - f0 == 1, "R11", "abort priority", abt_cnt - f0, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule